// File: doc/BRIEF.md
# Multi-Mode Analog Compare Unit

This block is a comparator function block for digitised analog readings. It receives two measured values, A1 and A2, and a reference value R. Each value is an unsigned count of 10 mV steps, so a span of 0 V to 9.99 V maps to 0 to 999. A 3-bit mode code picks one of seven comparisons. The outcome is stored in a single registered status bit.

An enable input acts as the rung condition that gates the block. While enable is low, or while the mode code is 0, the status bit is cleared. Otherwise the status bit follows the selected comparison, one clock after the inputs are presented. The window mode tests A1 against a band centred on A2 with half-width R. The band is computed with extra headroom: its lower edge saturates at zero, and its upper edge can rise above the input range without wrapping.

Top module: `analog_compare_unit`

## Requirements
- R1: With mode code 1, the status is 1 exactly when A2 − R ≤ A1 ≤ A2 + R, both bounds inclusive. The lower bound is clamped at 0 when R exceeds A2. The upper bound does not wrap when A2 + R exceeds the value width.
- R2: With mode code 2, the status is 1 exactly when A1 ≤ A2.
- R3: With mode code 3, the status is 1 exactly when A1 ≥ A2.
- R4: With mode code 4, the status is 1 exactly when A1 ≤ R.
- R5: With mode code 5, the status is 1 exactly when A1 ≥ R.
- R6: With mode code 6, the status is 1 exactly when A2 ≤ R.
- R7: With mode code 7, the status is 1 exactly when A2 ≥ R.
- R8: When enable is low, the status is 0 on the next clock, whatever the mode and values are.
- R9: When the mode code is 0, the status is 0 on the next clock, even with enable high.
- R10: The status is registered. It reflects the inputs present at the previous rising clock edge, and it is 0 while the active-low reset is asserted.
- R11: Operands a mode does not use have no effect on the status. R is unused in modes 2 and 3. A2 is unused in modes 4 and 5. A1 is unused in modes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Rung condition; low forces the status to 0 |
| mode | input | 3 | Comparison select, 0 = off, 1..7 as in R1..R7 |
| a1 | input | VAL_W (10) | First reading, in units of 10 mV |
| a2 | input | VAL_W (10) | Second reading, in units of 10 mV |
| refVal | input | VAL_W (10) | Reference or window half-width R, in units of 10 mV |
| status | output | 1 | Registered comparison result |

## Verification
The bench builds the block with the default VAL_W of 10. At that width the operands can reach 1023, so A2 + R can reach 2046. Directed steps drive the window into both edge cases: R larger than A2, which exercises the lower clamp, and A2 + R above 1023, which exercises the upper headroom. Each edge is also tested one count inside and one count outside. Randomised steps cover all eight mode codes with enable toggling, and they vary the unused operands in every mode.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_WINDOW   = 3'd1,
    MODE_A1_LE_A2 = 3'd2,
    MODE_A1_GE_A2 = 3'd3,
    MODE_A1_LE_R  = 3'd4,
    MODE_A1_GE_R  = 3'd5,
    MODE_A2_LE_R  = 3'd6,
    MODE_A2_GE_R  = 3'd7
  } cmpMode_e;

  // Strobes from control into the datapath
  typedef struct packed {
    logic active;    // result may be 1
    logic window;    // use the band test
    logic lessEq;    // 1: left <= right, 0: left >= right
    logic leftA2;    // left operand is A2 instead of A1
    logic rightRef;  // right operand is R instead of A2
  } cmpStrobe_t;

endpackage

// File: rtl/acmp_ctrl.sv
module acmp_ctrl
  import acmp_pkg::*;
(
  input  logic       enable,
  input  logic [2:0] mode,
  output cmpStrobe_t strobe
);

  cmpMode_e modeSel;
  assign modeSel = cmpMode_e'(mode);

  always_comb begin
    strobe          = '0;
    strobe.active   = enable && (modeSel != MODE_OFF);
    unique case (modeSel)
      MODE_WINDOW:   strobe.window = 1'b1;
      MODE_A1_LE_A2: strobe.lessEq = 1'b1;
      MODE_A1_GE_A2: strobe.lessEq = 1'b0;
      MODE_A1_LE_R:  begin strobe.lessEq = 1'b1; strobe.rightRef = 1'b1; end
      MODE_A1_GE_R:  strobe.rightRef = 1'b1;
      MODE_A2_LE_R:  begin strobe.lessEq = 1'b1; strobe.leftA2 = 1'b1; strobe.rightRef = 1'b1; end
      MODE_A2_GE_R:  begin strobe.leftA2 = 1'b1; strobe.rightRef = 1'b1; end
      default:       strobe.window = 1'b0;
    endcase
  end

  // R9: mode 0 never activates the datapath
  always_comb begin
    if (modeSel == MODE_OFF) a_r9_off_inactive: assert (!strobe.active);
  end

endmodule

// File: rtl/acmp_datapath.sv
module acmp_datapath
  import acmp_pkg::*;
#(
  parameter int VAL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t       strobe,
  input  logic [VAL_W-1:0] a1,
  input  logic [VAL_W-1:0] a2,
  input  logic [VAL_W-1:0] refVal,
  output logic             statusQ
);

  localparam int EXT_W = VAL_W + 2;  // sign bit plus carry headroom

  logic signed [EXT_W-1:0] a1Ext, a2Ext, refExt;
  logic signed [EXT_W-1:0] bandLo, bandHi;
  logic [VAL_W-1:0]        leftOp, rightOp;
  logic                    inBand, relHit, resultD;

  assign a1Ext  = signed'({2'b00, a1});
  assign a2Ext  = signed'({2'b00, a2});
  assign refExt = signed'({2'b00, refVal});

  // R1: wide arithmetic; a negative lower edge acts as a clamp at zero
  assign bandLo = a2Ext - refExt;
  assign bandHi = a2Ext + refExt;
  assign inBand = (a1Ext >= bandLo) && (a1Ext <= bandHi);

  assign leftOp  = strobe.leftA2   ? a2     : a1;
  assign rightOp = strobe.rightRef ? refVal : a2;
  assign relHit  = strobe.lessEq ? (leftOp <= rightOp) : (leftOp >= rightOp);

  assign resultD = strobe.active && (strobe.window ? inBand : relHit);

  // R10: registered result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= 1'b0;
    else       statusQ <= resultD;
  end

  // R10: an inactive strobe leads to a low status next cycle
  a_r10_inactive_low: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> !statusQ);

endmodule

// File: rtl/analog_compare_unit.sv
module analog_compare_unit
  import acmp_pkg::*;
#(
  parameter int VAL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [2:0]       mode,
  input  logic [VAL_W-1:0] a1,
  input  logic [VAL_W-1:0] a2,
  input  logic [VAL_W-1:0] refVal,
  output logic             status
);

  cmpStrobe_t strobe;

  acmp_ctrl u_ctrl (
    .enable (enable),
    .mode   (mode),
    .strobe (strobe)
  );

  acmp_datapath #(.VAL_W(VAL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .a1      (a1),
    .a2      (a2),
    .refVal  (refVal),
    .statusQ (status)
  );

  a_r8_enable_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !status);

  a_r1_window: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 3'd1) |=>
      status == ((int'($past(a1)) >= int'($past(a2)) - int'($past(refVal))) &&
                 (int'($past(a1)) <= int'($past(a2)) + int'($past(refVal)))));

  a_r2_a1_le_a2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 3'd2) |=> status == ($past(a1) <= $past(a2)));

  a_r5_a1_ge_ref: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 3'd5) |=> status == ($past(a1) >= $past(refVal)));

  a_r7_a2_ge_ref: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 3'd7) |=> status == ($past(a2) >= $past(refVal)));

endmodule

// File: tb/test_analog_compare_unit.sv
module test_analog_compare_unit;

  localparam int VAL_W = 10;
  localparam int VMAX  = (1 << VAL_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [2:0]       mode = 3'd0;
  logic [VAL_W-1:0] a1 = '0, a2 = '0, refVal = '0;
  logic             status;

  int checks = 0;
  int errors = 0;
  logic  expNext = 1'b0;
  string tagNext = "R10";

  always #5 clk = ~clk;

  analog_compare_unit #(.VAL_W(VAL_W)) i_analog_compare_unit (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .a1(a1), .a2(a2), .refVal(refVal), .status(status)
  );

  function automatic logic refModel(input logic en, input int m,
                                    input int x1, input int x2, input int rv);
    if (!en) return 1'b0;               // R8
    case (m)
      1: return (x1 >= x2 - rv) && (x1 <= x2 + rv);  // R1
      2: return x1 <= x2;               // R2
      3: return x1 >= x2;               // R3
      4: return x1 <= rv;               // R4
      5: return x1 >= rv;               // R5
      6: return x2 <= rv;               // R6
      7: return x2 >= rv;               // R7
      default: return 1'b0;             // R9
    endcase
  endfunction

  function automatic string modeTag(input logic en, input int m);
    if (!en) return "R8";
    if (m == 0) return "R9";
    return $sformatf("R%0d", m);
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s status=%0b expected=%0b", tag, got, exp);
    end
  endtask

  // Compare the output for the previous step, then apply a new one
  task automatic step(input logic en, input int m, input int x1, input int x2,
                      input int rv, input string tagOverride = "");
    @(negedge clk);
    check(status, expNext, tagNext);
    enable = en; mode = 3'(m);
    a1 = VAL_W'(x1); a2 = VAL_W'(x2); refVal = VAL_W'(rv);
    expNext = refModel(en, m, x1, x2, rv);
    tagNext = (tagOverride != "") ? tagOverride : modeTag(en, m);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired status=%0b expected=finish", status);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    enable = 1'b1; mode = 3'd3; a1 = 10'd500; a2 = 10'd100;
    repeat (3) @(negedge clk);
    check(status, 1'b0, "R10");
    rstN = 1'b1;
    expNext = refModel(1'b1, 3, 500, 100, 0);
    tagNext = "R10";

    // R1 window edges, clamp and headroom
    step(1, 1, 90, 100, 10);
    step(1, 1, 89, 100, 10);
    step(1, 1, 110, 100, 10);
    step(1, 1, 111, 100, 10);
    step(1, 1, 0, 5, 10, "R1");        // lower edge clamped to 0
    step(1, 1, 15, 5, 10, "R1");
    step(1, 1, 16, 5, 10, "R1");
    step(1, 1, 1023, 1000, 1000, "R1"); // upper edge 2000, no wrap
    step(1, 1, 0, 1000, 1000, "R1");
    // R2..R7 equality and one-off points
    step(1, 2, 300, 300, 0);
    step(1, 2, 301, 300, 0);
    step(1, 3, 299, 300, 0);
    step(1, 3, 300, 300, 0);
    step(1, 4, 999, 0, 999);
    step(1, 5, 0, 0, 1);
    step(1, 6, 0, 500, 500);
    step(1, 7, 0, 499, 500);
    // R11: vary only the unused operand; output must stay the same
    step(1, 2, 100, 200, 0, "R11");
    step(1, 2, 100, 200, 1023, "R11");
    step(1, 4, 100, 0, 200, "R11");
    step(1, 4, 100, 1023, 200, "R11");
    step(1, 7, 0, 600, 500, "R11");
    step(1, 7, 1023, 600, 500, "R11");
    // R8 and R9 with operands that would otherwise give a 1
    step(0, 2, 0, 999, 0);
    step(1, 0, 0, 999, 0);
    step(1, 2, 0, 999, 0);

    // Randomised sweep over all modes
    for (int i = 0; i < 2000; i++) begin
      int pick = int'($urandom_range(0, 3));
      int x2 = int'($urandom_range(0, VMAX));
      int rv = int'($urandom_range(0, VMAX));
      int x1 = (pick == 0) ? x2 + int'($urandom_range(0, 2)) - 1 : int'($urandom_range(0, VMAX));
      if (x1 < 0) x1 = 0;
      if (x1 > VMAX) x1 = VMAX;
      if (pick == 1) rv = int'($urandom_range(0, 40));
      step(logic'($urandom_range(0, 7) != 0), int'($urandom_range(0, 7)), x1, x2, rv);
    end

    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check(status, expNext, tagNext);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule